// File: doc/BRIEF.md
# Programmable interval counter channel

This block is a single timing channel built around one down counter. The counter steps once on every rising edge of `clk` and can run as plain binary or as four packed decimal digits. A host-side interface sits outside the block and handles bus decoding and byte ordering. That interface hands the channel three things:

- a configuration write, carrying a mode code and a decimal-count flag;
- a count write, carrying a 16-bit start value;
- a `gate` level that either holds the count or triggers it, depending on the mode.

The channel drives a single output line, `out`. Depending on the mode, that line is a terminal-count flag, a retriggerable pulse, a periodic strobe, a square wave or a single strobe. The live counter value is always visible on `count`, so the host can latch it whenever it wants.

Both write pulses are accepted in the cycle they are asserted. The channel never applies back-pressure, and the host never waits. A configuration write takes priority over a count write in the same cycle. Gate edges are detected on `clk`, so the host must present `gate` synchronous to `clk`.

Top module: `pit_channel`

## Requirements
- R1: In binary counting the counter drops by one per enabled clock, and a loaded value of 0 acts as the largest count: the value after it is 16'hFFFF.
- R2: With the decimal flag set, every 4-bit nibble is one decimal digit and the counter steps through 9999..0. For example 16'h0010 goes to 16'h0009, 16'h0100 goes to 16'h0099, and 0 acts as 10000, so the value after it is 16'h9999.
- R3: Mode 0 (terminal-count flag):
  - A count write of N sets `count` to N and drives `out` low.
  - `out` rises N clocks after the write edge.
  - `out` stays high while the counter wraps, until the next count or configuration write.
- R4: In modes 0, 2, 3 and 4, `gate` low holds `count` at its current value, and counting resumes from that value when `gate` returns high.
- R5: Mode 1 (one-shot):
  - Nothing counts until a rising edge of `gate`.
  - That edge loads the stored count N and drives `out` low.
  - `out` stays low for exactly N clocks.
- R6: In mode 1, a count write during an active pulse leaves the running count and the pulse length unchanged. The next rising gate edge loads the new value, and a rising edge during the pulse restarts it from the full value.
- R7: Mode 2 (rate, N of at least 2): `out` is high except for one clock in every N. The first low clock comes N clocks after the count write, and the counter then reloads N.
- R8: Mode 3 (square wave): the period is N clocks. `out` is high for ceil(N/2) clocks, then low for floor(N/2) clocks.
- R9: Mode 4 (software strobe):
  - Counting starts at the count write itself.
  - `out` goes low for exactly one clock, N clocks after the write.
  - The counter then stops at 0 and does not repeat.
- R10: Mode 5 (hardware strobe): a count write alone starts nothing. A rising gate edge loads N, `out` goes low for one clock N clocks later, and each further rising edge repeats this.
- R11: Mode codes are 3 bits. Codes 0 to 5 select modes 0 to 5. Code 6 acts exactly as code 2 and code 7 acts exactly as code 3.
- R12: Reset state and configuration writes:
  - After reset, `out` is high and `count` is 0.
  - A configuration write stops counting.
  - After a configuration write, `out` is low for mode 0 and high for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Hold level or trigger edge, depending on mode |
| cfg_wr | input | 1 | One-cycle pulse: take cfg_mode and cfg_bcd |
| cfg_mode | input | 3 | Mode code (6 and 7 alias 2 and 3) |
| cfg_bcd | input | 1 | 1 = four-digit decimal counting |
| cnt_wr | input | 1 | One-cycle pulse: take cnt_val as the new count |
| cnt_val | input | 16 | Count value |
| out | output | 1 | Channel output line |
| count | output | 16 | Live counter value |

## Verification
A wrong counter value, or a wrong decrement step, shows on `count` in the very next cycle. It reaches `out` only at the terminal cycle, so the bench samples `count` as soon as it changes and checks `out` exactly at its predicted edge.

A wrong run flag or a wrong gate-edge state shows at the ports in one of two ways:
- a strobe or pulse that starts without its trigger;
- a strobe or pulse that never ends.

The bench catches both within a few cycles of the gate edge.

A wrong period register only shows as a mis-sized high or low phase one full period later. For that reason the rate and square-wave cases watch at least two complete periods.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    MODE_TC_FLAG   = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } pit_mode_e;

  // Codes above 5 drop their top bit: 6 -> 2, 7 -> 3.
  function automatic pit_mode_e fold_mode(input logic [2:0] code);
    logic [2:0] folded;
    folded = (code > 3'd5) ? (code & 3'b011) : code;
    return pit_mode_e'(folded);
  endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;

  // A rising edge needs gate low in the sampled cycle before, so two in a row are impossible.
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pit_decrement.sv
module pit_decrement #(
  parameter  int DIGITS = 4,
  localparam int CNT_W  = 4 * DIGITS
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] dec_o
);

  logic [DIGITS:0]    borrow;
  logic [CNT_W-1:0]   dec_dec;
  logic [DIGITS-1:0]  in_ok;
  logic [DIGITS-1:0]  out_ok;

  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] d;
    assign d              = val_i[4*i +: 4];
    assign borrow[i+1]    = borrow[i] & (d == 4'd0);
    assign dec_dec[4*i +: 4] = !borrow[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    assign in_ok[i]       = (d <= 4'd9);
    assign out_ok[i]      = (dec_dec[4*i +: 4] <= 4'd9);
  end

  assign dec_o = bcd_i ? dec_dec : (val_i - CNT_W'(1));

  // R2: valid decimal digits in must give valid decimal digits out.
  always_comb begin
    if (bcd_i && (&in_ok)) begin
      assert_bcd_digits_R2: assert (&out_ok);
    end
  end

endmodule

// File: rtl/pit_half.sv
module pit_half #(
  parameter  int DIGITS = 4,
  localparam int CNT_W  = 4 * DIGITS
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] half_o
);

  logic [CNT_W-1:0] half_bin;
  logic [CNT_W-1:0] half_dec;
  logic             is_zero;

  assign is_zero  = (val_i == '0);
  assign half_bin = val_i >> 1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] d;
    logic       carry_five;
    assign d = val_i[4*i +: 4];
    if (i == DIGITS - 1) begin : g_top
      assign carry_five = 1'b0;
    end else begin : g_mid
      assign carry_five = val_i[4*(i+1)];
    end
    assign half_dec[4*i +: 4] = {1'b0, d[3:1]} + (carry_five ? 4'd5 : 4'd0);
  end

  // A zero period stands for the full range, so its half is the top weight.
  always_comb begin
    if (!is_zero)   half_o = bcd_i ? half_dec : half_bin;
    else if (bcd_i) half_o = {4'd5, {(CNT_W-4){1'b0}}};
    else            half_o = {1'b1, {(CNT_W-1){1'b0}}};
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter  int DIGITS = 4,
  localparam int CNT_W  = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_bcd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             out,
  output logic [CNT_W-1:0] count
);

  pit_mode_e        mode_q, mode_n;
  logic             bcd_q, bcd_n;
  logic [CNT_W-1:0] reload_q, reload_n;
  logic [CNT_W-1:0] period_q, period_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             out_q, out_n;
  logic             run_q, run_n;

  logic             gate_rise;
  logic [CNT_W-1:0] dec_val;
  logic             at_end;
  logic [CNT_W-1:0] sq_period, sq_next, sq_half;
  logic             sq_out;
  logic             strobe_mode, gated_mode, count_en;
  logic             write_starts, trig;
  logic [CNT_W-1:0] load_src;
  pit_mode_e        cfg_folded;

  pit_gate_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  pit_decrement #(.DIGITS(DIGITS)) u_dec (
    .val_i (cnt_q),
    .bcd_i (bcd_q),
    .dec_o (dec_val)
  );

  assign at_end    = (dec_val == '0);
  assign sq_period = at_end ? reload_q : period_q;
  assign sq_next   = at_end ? reload_q : dec_val;

  pit_half #(.DIGITS(DIGITS)) u_half (
    .val_i  (sq_period),
    .bcd_i  (bcd_q),
    .half_o (sq_half)
  );

  assign sq_out      = (sq_next == '0) || (sq_next > sq_half);
  assign cfg_folded  = fold_mode(cfg_mode);
  assign strobe_mode = (mode_q == MODE_RATE) || (mode_q == MODE_SW_STROBE) ||
                       (mode_q == MODE_HW_STROBE);
  assign gated_mode  = (mode_q == MODE_TC_FLAG) || (mode_q == MODE_RATE) ||
                       (mode_q == MODE_SQUARE) || (mode_q == MODE_SW_STROBE);
  assign count_en    = gated_mode ? gate : 1'b1;
  assign write_starts = cnt_wr && ((mode_q == MODE_TC_FLAG) || (mode_q == MODE_SW_STROBE) ||
                        (((mode_q == MODE_RATE) || (mode_q == MODE_SQUARE)) && !run_q));
  assign trig        = gate_rise && ((mode_q == MODE_ONESHOT) || (mode_q == MODE_HW_STROBE));
  assign load_src    = cnt_wr ? cnt_val : reload_q;

  always_comb begin
    mode_n   = mode_q;
    bcd_n    = bcd_q;
    reload_n = reload_q;
    period_n = period_q;
    cnt_n    = cnt_q;
    out_n    = out_q;
    run_n    = run_q;
    if (strobe_mode && !out_q) out_n = 1'b1;
    if (cfg_wr) begin
      mode_n = cfg_folded;
      bcd_n  = cfg_bcd;
      run_n  = 1'b0;
      out_n  = (cfg_folded != MODE_TC_FLAG);
    end else if (write_starts) begin
      reload_n = cnt_val;
      period_n = cnt_val;
      cnt_n    = cnt_val;
      run_n    = 1'b1;
      out_n    = (mode_q != MODE_TC_FLAG);
    end else begin
      if (cnt_wr) reload_n = cnt_val;
      if (trig) begin
        cnt_n    = load_src;
        period_n = load_src;
        run_n    = 1'b1;
        out_n    = (mode_q != MODE_ONESHOT);
      end else if (run_q && count_en) begin
        case (mode_q)
          MODE_TC_FLAG: begin
            cnt_n = dec_val;
            if (at_end) out_n = 1'b1;
          end
          MODE_ONESHOT: begin
            cnt_n = dec_val;
            if (at_end) begin
              out_n = 1'b1;
              run_n = 1'b0;
            end
          end
          MODE_RATE: begin
            cnt_n    = sq_next;
            period_n = sq_period;
            if (at_end) out_n = 1'b0;
          end
          MODE_SQUARE: begin
            cnt_n    = sq_next;
            period_n = sq_period;
            out_n    = sq_out;
          end
          MODE_SW_STROBE, MODE_HW_STROBE: begin
            cnt_n = dec_val;
            if (at_end) begin
              out_n = 1'b0;
              run_n = 1'b0;
            end
          end
          default: cnt_n = cnt_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_TC_FLAG;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      period_q <= '0;
      cnt_q    <= '0;
      out_q    <= 1'b1;
      run_q    <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      bcd_q    <= bcd_n;
      reload_q <= reload_n;
      period_q <= period_n;
      cnt_q    <= cnt_n;
      out_q    <= out_n;
      run_q    <= run_n;
    end
  end

  assign out   = out_q;
  assign count = cnt_q;

  // Strobe lows last exactly one clock (R7, R9, R10).
  assert_strobe_one_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_mode && !out_q && !cfg_wr && (period_q != CNT_W'(1))) |=> out_q);

  // Terminal-count flag stays set until a write (R3).
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_TC_FLAG) && out_q && !cfg_wr && !cnt_wr) |=> out_q);

  // Gate low freezes the counter in level-gated modes (R4).
  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && run_q && !gate && !cfg_wr && !cnt_wr) |=> $stable(count));

  // A low one-shot output always belongs to a running count (R5).
  assert_pulse_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_ONESHOT) && !out_q) |-> run_q);

endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_bcd = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic        out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst_n(rst_n), .gate(gate),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .out(out), .count(count)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [2:0] m, input logic b);
    cfg_wr = 1'b1; cfg_mode = m; cfg_bcd = b;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic do_wr(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_val = v;
    tick(1);
    cnt_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "reset out", int'(out), 1);
    chk("R12", "reset count", int'(count), 0);
  endtask

  task automatic t_flag();
    gate = 1'b1;
    do_cfg(3'd0, 1'b0);
    chk("R12", "mode0 cfg out", int'(out), 0);
    do_wr(16'd5);
    chk("R3", "load count", int'(count), 5);
    tick(1);
    chk("R1", "step", int'(count), 4);
    tick(3);
    chk("R3", "out before end", int'(out), 0);
    tick(1);
    chk("R3", "out at end", int'(out), 1);
    tick(3);
    chk("R3", "out sticky", int'(out), 1);
    do_wr(16'd2);
    chk("R3", "rewrite lowers out", int'(out), 0);
  endtask

  task automatic t_gate_hold();
    gate = 1'b1;
    do_cfg(3'd0, 1'b0);
    do_wr(16'd6);
    tick(2);
    chk("R4", "before hold", int'(count), 4);
    gate = 1'b0;
    tick(3);
    chk("R4", "held", int'(count), 4);
    gate = 1'b1;
    tick(1);
    chk("R4", "resumed", int'(count), 3);
  endtask

  task automatic t_wrap();
    gate = 1'b1;
    do_cfg(3'd0, 1'b0);
    do_wr(16'd0);
    tick(1);
    chk("R1", "binary max", int'(count), 16'hFFFF);
    do_cfg(3'd0, 1'b1);
    do_wr(16'd0);
    tick(1);
    chk("R2", "decimal max", int'(count), 16'h9999);
    do_wr(16'h0010);
    tick(1);
    chk("R2", "decimal 10", int'(count), 16'h0009);
    do_wr(16'h0100);
    tick(1);
    chk("R2", "decimal 100", int'(count), 16'h0099);
  endtask

  task automatic t_oneshot();
    gate = 1'b0;
    do_cfg(3'd1, 1'b0);
    chk("R12", "mode1 cfg out", int'(out), 1);
    do_wr(16'd4);
    tick(3);
    chk("R5", "no start without edge", int'(out), 1);
    gate = 1'b1;
    tick(1);
    chk("R5", "trigger load", int'(count), 4);
    chk("R5", "pulse low", int'(out), 0);
    do_wr(16'd8);
    chk("R6", "write in pulse", int'(count), 3);
    tick(2);
    chk("R6", "pulse still low", int'(out), 0);
    tick(1);
    chk("R6", "pulse length kept", int'(out), 1);
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(1);
    chk("R6", "new value on edge", int'(count), 8);
    tick(2);
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(1);
    chk("R6", "retrigger reload", int'(count), 8);
    tick(7);
    chk("R6", "retrigger extends", int'(out), 0);
    tick(1);
    chk("R5", "pulse end", int'(out), 1);
  endtask

  task automatic t_rate(input logic [2:0] code);
    int lows = 0;
    gate = 1'b1;
    do_cfg(code, 1'b0);
    do_wr(16'd4);
    chk("R7", "rate start out", int'(out), 1);
    for (int k = 1; k <= 12; k++) begin
      tick(1);
      if (!out) lows++;
      chk(code == 3'd6 ? "R11" : "R7", "rate out", int'(out), (k % 4 != 0) ? 1 : 0);
    end
    chk("R7", "rate lows", lows, 3);
  endtask

  task automatic t_rate_dec();
    gate = 1'b1;
    do_cfg(3'd2, 1'b1);
    do_wr(16'h0012);
    tick(3);
    chk("R2", "decimal rate step", int'(count), 16'h0009);
    tick(9);
    chk("R2", "decimal period", int'(out), 0);
    chk("R2", "decimal reload", int'(count), 16'h0012);
  endtask

  task automatic t_square(input logic [2:0] code, input logic [15:0] n);
    gate = 1'b1;
    do_cfg(code, 1'b0);
    do_wr(n);
    chk("R8", "square start", int'(out), 1);
    for (int k = 1; k <= 2 * int'(n); k++) begin
      tick(1);
      chk(code == 3'd7 ? "R11" : "R8", "square out", int'(out),
          ((k % int'(n)) < (int'(n) + 1) / 2) ? 1 : 0);
    end
  endtask

  task automatic t_sw_strobe();
    gate = 1'b1;
    do_cfg(3'd4, 1'b0);
    do_wr(16'd3);
    chk("R9", "start count", int'(count), 3);
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      chk("R9", "strobe out", int'(out), (k == 3) ? 0 : 1);
    end
    chk("R9", "stopped at zero", int'(count), 0);
  endtask

  task automatic t_hw_strobe();
    gate = 1'b0;
    do_cfg(3'd5, 1'b0);
    do_wr(16'd3);
    tick(4);
    chk("R10", "no start on write", int'(out), 1);
    gate = 1'b1;
    tick(1);
    chk("R10", "edge load", int'(count), 3);
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      chk("R10", "strobe out", int'(out), (k == 3) ? 0 : 1);
    end
    gate = 1'b0; tick(1);
    gate = 1'b1; tick(1);
    tick(3);
    chk("R10", "second strobe", int'(out), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_flag();
    t_gate_hold();
    t_wrap();
    t_oneshot();
    t_rate(3'd2);
    t_rate(3'd6);
    t_rate_dec();
    t_square(3'd3, 16'd5);
    t_square(3'd3, 16'd4);
    t_square(3'd7, 16'd5);
    t_sw_strobe();
    t_hw_strobe();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule